// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit channel of a classic programmable interval timer. It runs on the system clock. It advances only on cycles where a one-cycle count-enable tick is high, so it has no notion of real time. A load strobe captures a reload value and a 3-bit mode together and restarts the counting sequence. A gate input either suspends counting or retriggers it, depending on the mode. The channel drives an output level and exposes its live counter value, which a separate bus block can latch and read. Counting is binary only.

Six behaviours are provided: interrupt on terminal count, retriggerable one-shot, rate generator, square wave, software strobe and hardware strobe. In the requirements, N is the programmed count and d is the number of effective ticks since the last load or restart. Mode values are the binary value on the 3-bit mode input. Values 0 to 5 select the behaviours in the order above; 6 acts as 2 and 7 acts as 3.

Top module: `interval_counter_ch`

## Requirements
- R1: After reset the channel is in mode 3 with N = 65536. The count port reads 0x0000 and the output is high.
- R2: A load strobe sets N to the reload value, with 0 meaning 65536, selects the mode and sets d = 0. The result shows on the cycle after the strobe. A load takes priority over a tick or a gate edge in the same cycle.
- R3: In modes 0 and 1 the output is low while d < N and high from d = N onward. The count reads (N - d) mod 65536, so it wraps after terminal count.
- R4: In modes 4 and 5 the output is high only while d == N and low otherwise, including after the count wraps. The count reads as in R3.
- R5: In mode 2 the count reads N - (d mod N), where 65536 reads as 0x0000. The output is high only while d is a positive multiple of N.
- R6: In mode 3 the output is high while (d mod N) < ceil(N/2). The count reads N - ((2*d) mod N), so it falls by two per tick.
- R7: Mode values 6 and 7 behave exactly as modes 2 and 3.
- R8: In modes 1, 2, 3 and 5, a clock where gate is sampled high after being sampled low on the previous clock sets d = 0. This restart wins over a tick in that cycle. The gate level has no other effect in these modes.
- R9: In modes 0 and 4 a tick counts only in a cycle where gate is high. A rising gate does not restart counting.
- R10: d changes by one only on a clock where tick is high and no load or restart occurs. Otherwise the output and count hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count-enable pulse |
| load | input | 1 | Strobe that captures reload_val and mode_sel and restarts counting |
| reload_val | input | 16 | Programmed count; 0 means 65536 |
| mode_sel | input | 3 | Counting mode, 0 to 7 |
| gate | input | 1 | Gate level, sampled every clock |
| cnt_out | output | 1 | Channel output level |
| count_val | output | 16 | Live counter value |

## Verification
Two collisions matter most. The first is a tick that lands on the same clock as a gate rising edge in a retriggerable mode. The second is a tick or gate edge that lands on the same clock as a load strobe. The bench provokes both in rate-generator mode while the count is mid-period, so a wrong winner is visible. The scoreboard expects d = 0 at the next clock, which means the count equals N and the output is in its start level, rather than d advanced by one. The same scoreboard also expects a rising gate in mode 0 to leave the count running rather than restart it.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   typedef enum logic [2:0] {
      MD_TC_INT   = 3'd0,
      MD_ONESHOT  = 3'd1,
      MD_RATE     = 3'd2,
      MD_SQUARE   = 3'd3,
      MD_SW_STRB  = 3'd4,
      MD_HW_STRB  = 3'd5
   } ivc_mode_e;

   function automatic ivc_mode_e fold_mode(input logic [2:0] raw);
      case (raw)
         3'd6:    fold_mode = MD_RATE;
         3'd7:    fold_mode = MD_SQUARE;
         default: fold_mode = ivc_mode_e'(raw);
      endcase
   endfunction

   function automatic logic edge_retrig(input ivc_mode_e m);
      edge_retrig = (m == MD_ONESHOT) || (m == MD_RATE) ||
                    (m == MD_SQUARE)  || (m == MD_HW_STRB);
   endfunction

   function automatic logic level_gated(input ivc_mode_e m);
      level_gated = (m == MD_TC_INT) || (m == MD_SW_STRB);
   endfunction

endpackage

// File: rtl/ivc_cfg.sv
module ivc_cfg
   import ivc_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int CW   = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic [2:0]       mode_raw_i,
   output logic [CW-1:0]    n_new_o,
   output ivc_mode_e        mode_new_o,
   output logic [CW-1:0]    n_q_o,
   output ivc_mode_e        mode_q_o
);

   localparam logic [CW-1:0] FULL_N = {1'b1, {CNT_W{1'b0}}};

   assign n_new_o    = (reload_i == '0) ? FULL_N : {1'b0, reload_i};
   assign mode_new_o = fold_mode(mode_raw_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q_o    <= FULL_N;
         mode_q_o <= MD_SQUARE;
      end else if (load_i) begin
         n_q_o    <= n_new_o;
         mode_q_o <= mode_new_o;
      end
   end

endmodule

// File: rtl/ivc_gate.sv
module ivc_gate
   import ivc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      gate_i,
   input  ivc_mode_e mode_i,
   output logic      restart_o,
   output logic      count_en_o
);

   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_i;
   end

   assign restart_o  = gate_i & ~gate_q & edge_retrig(mode_i);
   assign count_en_o = level_gated(mode_i) ? gate_i : 1'b1;

endmodule

// File: rtl/ivc_core.sv
module ivc_core
   import ivc_pkg::*;
#(
   parameter int CNT_W = 16,
   localparam int CW   = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic             load_i,
   input  logic [CW-1:0]    n_new_i,
   input  ivc_mode_e        mode_new_i,
   input  logic [CW-1:0]    n_i,
   input  ivc_mode_e        mode_i,
   output logic             out_o,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CW-1:0] FULL_N = {1'b1, {CNT_W{1'b0}}};

   logic [CW-1:0] ph, vis;
   logic          out_q, fired;

   logic          start, advance;
   logic [CW-1:0] start_n;
   ivc_mode_e     start_m;
   logic [CW-1:0] ph_inc, ph_nxt, half, sq_t, sq_vis, dn_vis;
   logic          hit;

   assign start   = load_i | restart_i;
   assign advance = tick_i & en_i & ~start;
   assign start_n = load_i ? n_new_i : n_i;
   assign start_m = load_i ? mode_new_i : mode_i;

   assign ph_inc = ph + CW'(1);
   assign ph_nxt = (ph_inc == n_i) ? '0 : ph_inc;
   assign half   = (n_i + CW'(1)) >> 1;
   assign sq_t   = vis + n_i - CW'(2);
   assign sq_vis = (vis > CW'(2)) ? (vis - CW'(2)) :
                   ((sq_t == '0) ? n_i : sq_t);
   assign dn_vis = {1'b0, vis[CNT_W-1:0] - CNT_W'(1)};
   assign hit    = (vis[CNT_W-1:0] == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= '0;
         vis   <= FULL_N;
         out_q <= 1'b1;
         fired <= 1'b0;
      end else if (start) begin
         ph    <= '0;
         vis   <= start_n;
         out_q <= (start_m == MD_SQUARE);
         fired <= 1'b0;
      end else if (advance) begin
         ph <= ph_nxt;
         case (mode_i)
            MD_RATE: begin
               vis   <= n_i - ph_nxt;
               out_q <= (ph_nxt == '0);
            end
            MD_SQUARE: begin
               vis   <= sq_vis;
               out_q <= (ph_nxt < half);
            end
            MD_SW_STRB, MD_HW_STRB: begin
               vis   <= dn_vis;
               out_q <= hit & ~fired;
               fired <= fired | hit;
            end
            default: begin
               vis   <= dn_vis;
               out_q <= out_q | hit;
            end
         endcase
      end
   end

   assign out_o   = out_q;
   assign count_o = vis[CNT_W-1:0];

   // R3
   tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && out_q && (mode_i == MD_TC_INT || mode_i == MD_ONESHOT)) |=> out_q);

   // R4
   strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && out_q && (mode_i == MD_SW_STRB || mode_i == MD_HW_STRB)) |=> !out_q);

   // R5
   rate_pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_RATE && out_q) |-> (vis == n_i));

   // R6
   square_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_SQUARE) |-> (vis != '0 && vis <= n_i));

   // R8
   retrig_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && !load_i) |=> (vis == n_i && ph == '0));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !start) |=> ($stable(vis) && $stable(out_q)));

endmodule

// File: rtl/interval_counter_ch.sv
module interval_counter_ch
   import ivc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [2:0]       mode_sel,
   input  logic             gate,
   output logic             cnt_out,
   output logic [CNT_W-1:0] count_val
);

   localparam int CW = CNT_W + 1;

   generate
      if (CNT_W < 2) begin : g_width_bad
         $error("interval_counter_ch: CNT_W must be at least 2");
      end
   endgenerate

   logic [CW-1:0] n_new, n_q;
   ivc_mode_e     mode_new, mode_q;
   logic          restart, count_en;

   ivc_cfg #(.CNT_W(CNT_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .reload_i   (reload_val),
      .mode_raw_i (mode_sel),
      .n_new_o    (n_new),
      .mode_new_o (mode_new),
      .n_q_o      (n_q),
      .mode_q_o   (mode_q)
   );

   ivc_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_i     (gate),
      .mode_i     (mode_q),
      .restart_o  (restart),
      .count_en_o (count_en)
   );

   ivc_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .en_i       (count_en),
      .restart_i  (restart),
      .load_i     (load),
      .n_new_i    (n_new),
      .mode_new_i (mode_new),
      .n_i        (n_q),
      .mode_i     (mode_q),
      .out_o      (cnt_out),
      .count_o    (count_val)
   );

endmodule

// File: tb/interval_counter_ch_tb.sv
`timescale 1ns/1ps
module interval_counter_ch_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        load = 1'b0;
   logic [15:0] reload_val = '0;
   logic [2:0]  mode_sel = '0;
   logic        gate = 1'b0;
   logic        cnt_out;
   logic [15:0] count_val;

   always #10 clk = ~clk;

   interval_counter_ch u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
      .reload_val(reload_val), .mode_sel(mode_sel), .gate(gate),
      .cnt_out(cnt_out), .count_val(count_val)
   );

   int checks = 0;
   int errors = 0;
   logic [16:0] exp_q[$];
   string       tag_q[$];
   bit          done = 0;

   longint m_n = 65536;
   longint m_d = 0;
   int     m_md = 3;
   logic   m_gp = 1'b0;

   function automatic logic [16:0] expect_now();
      logic o;
      longint c;
      case (m_md)
         0, 1:    o = (m_d >= m_n);
         4, 5:    o = (m_d == m_n);
         2:       o = (m_d > 0) && ((m_d % m_n) == 0);
         default: o = ((m_d % m_n) < ((m_n + 1) / 2));
      endcase
      if (m_md == 3)      c = m_n - ((2 * m_d) % m_n);
      else if (m_md == 2) c = m_n - (m_d % m_n);
      else                c = m_n - m_d;
      expect_now = {o, 16'(c & 64'hffff)};
   endfunction

   task automatic step(input logic tk, input logic g, input logic ld,
                       input logic [15:0] v, input logic [2:0] m, input string tg);
      logic gp;
      @(negedge clk);
      tick = tk; gate = g; load = ld; reload_val = v; mode_sel = m;
      gp = m_gp;
      m_gp = g;
      if (ld) begin
         m_n  = (v == 16'd0) ? 65536 : longint'(v);
         m_md = (m >= 3'd6) ? int'(m) - 4 : int'(m);
         m_d  = 0;
      end else if (g && !gp && (m_md == 1 || m_md == 2 || m_md == 3 || m_md == 5)) begin
         m_d = 0;
      end else if (tk && ((m_md == 0 || m_md == 4) ? g : 1'b1)) begin
         m_d = m_d + 1;
      end
      exp_q.push_back(expect_now());
      tag_q.push_back(tg);
   endtask

   task automatic run(input int n, input logic tk, input logic g, input string tg);
      for (int i = 0; i < n; i++) step(tk, g, 1'b0, 16'd0, 3'd0, tg);
   endtask

   // monitor: compares one expected item per clock, 1 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [16:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({cnt_out, count_val} !== e) begin
               errors++;
               $display("FAIL %s: out=%0b count=%h expected out=%0b count=%h",
                        t, cnt_out, count_val, e[16], e[15:0]);
            end
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: out=%0b count=%h expected run to end", cnt_out, count_val);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(1'b0, 1'b0, 1'b0, 16'd0, 3'd0, "R1 reset");
      step(1'b0, 1'b0, 1'b0, 16'd0, 3'd0, "R1 reset hold");

      // R2/R3 mode 0, N=5
      step(1'b0, 1'b1, 1'b1, 16'd5, 3'd0, "R2 load mode0");
      run(8, 1'b1, 1'b1, "R3 mode0 count");
      // R10 ticks with gaps
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b1, 1'b0, 16'd0, 3'd0, "R10 no tick");
         step(1'b1, 1'b1, 1'b0, 16'd0, 3'd0, "R10 tick");
      end
      // R9 gate low suspends, rising gate does not restart
      run(3, 1'b1, 1'b0, "R9 mode0 gate low");
      run(2, 1'b1, 1'b1, "R9 mode0 gate rise");

      // R3 mode 1, N=4, R8 retrigger
      step(1'b0, 1'b1, 1'b1, 16'd4, 3'd1, "R2 load mode1");
      run(6, 1'b1, 1'b1, "R3 mode1");
      run(2, 1'b1, 1'b0, "R8 mode1 gate low");
      run(3, 1'b1, 1'b1, "R8 mode1 retrigger");

      // R5 mode 2, N=3
      step(1'b0, 1'b1, 1'b1, 16'd3, 3'd2, "R2 load mode2");
      run(8, 1'b1, 1'b1, "R5 mode2");
      run(2, 1'b1, 1'b0, "R8 mode2 gate level ignored");
      // R8 gate rise collides with tick: restart wins
      run(3, 1'b1, 1'b1, "R8 mode2 rise with tick");
      // R2 load collides with tick
      step(1'b1, 1'b1, 1'b1, 16'd7, 3'd2, "R2 load with tick");
      run(9, 1'b1, 1'b1, "R5 mode2 N7");

      // R6 mode 3
      step(1'b0, 1'b1, 1'b1, 16'd6, 3'd3, "R2 load mode3");
      run(8, 1'b1, 1'b1, "R6 mode3 even");
      step(1'b0, 1'b1, 1'b1, 16'd5, 3'd3, "R2 load mode3 odd");
      run(11, 1'b1, 1'b1, "R6 mode3 odd");
      step(1'b0, 1'b1, 1'b1, 16'd1, 3'd3, "R2 load mode3 one");
      run(3, 1'b1, 1'b1, "R6 mode3 N1");

      // R7 aliases
      step(1'b0, 1'b1, 1'b1, 16'd4, 3'd7, "R7 load mode7");
      run(6, 1'b1, 1'b1, "R7 mode7 as square");
      step(1'b0, 1'b1, 1'b1, 16'd3, 3'd6, "R7 load mode6");
      run(5, 1'b1, 1'b1, "R7 mode6 as rate");

      // R2 count 0 means 65536
      step(1'b0, 1'b1, 1'b1, 16'd0, 3'd3, "R2 zero mode3");
      run(3, 1'b1, 1'b1, "R2 zero mode3 step");
      step(1'b0, 1'b1, 1'b1, 16'd0, 3'd0, "R2 zero mode0");
      run(3, 1'b1, 1'b1, "R2 zero mode0 step");

      // R4 mode 5, N=3, retrigger
      step(1'b0, 1'b1, 1'b1, 16'd3, 3'd5, "R2 load mode5");
      run(6, 1'b1, 1'b1, "R4 mode5");
      step(1'b1, 1'b0, 1'b0, 16'd0, 3'd0, "R8 mode5 gate low");
      run(5, 1'b1, 1'b1, "R8 mode5 retrigger");

      // R4 mode 4, N=2, past the wrap; R9 gate low holds
      step(1'b0, 1'b1, 1'b1, 16'd2, 3'd4, "R2 load mode4");
      run(3, 1'b1, 1'b0, "R9 mode4 gate low");
      run(65540, 1'b1, 1'b1, "R4 mode4 wrap");

      step(1'b0, 1'b1, 1'b0, 16'd0, 3'd0, "R10 final idle");
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule